// File: doc/BRIEF.md
# Synchronous Serial Port Register and FIFO Controller

This block is the processor-facing side of a synchronous serial port. A CPU reaches it through a single-cycle APB-style register interface. Through that interface it sets the frame width, enables the port, and chooses between a built-in loopback path and an external transfer engine. It pushes words into an 8-deep transmit queue and pulls words from an 8-deep receive queue, both through one data register. The block derives the status flags, the raw and masked interrupt sources and a level interrupt line from the two queue occupancies. It also exposes a fixed identification window.

When the port is enabled, transmit words leave the queue in one of two ways. In loopback they move straight into the receive queue. Otherwise they go to the external engine through a valid/ready pair. The engine hands each received word back on a separate valid input. Only one word is in flight at a time, and a word is launched only when the receive queue has room, so the receive side can never overrun. Line timing, clock prescaling, DMA and slave operation are not built. Requests for DMA or for slave operation set a sticky error flag instead.

Top module: `ssp_regfile`

## Requirements
- R1: After reset both queues are empty, the interrupt mask is 0, the raw interrupt register (offset 0x18) reads 0x08, the status register (offset 0x0C) reads 0x03, and `irq` and `err` are low.
- R2: Status bits are: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy. Busy is high while the transmit queue holds any word.
- R3: A write to the data register (offset 0x08) while the transmit queue holds 8 words is discarded.
- R4: A read of the data register while the receive queue is empty returns 0 and removes nothing.
- R5: Raw interrupt bit 2 is high when the receive queue holds 4 or more words. Raw interrupt bit 3 is high when the transmit queue holds 4 or fewer words. Raw bits 1:0 read 0.
- R6: The masked status register (offset 0x1C) reads raw AND mask, where the mask is at offset 0x14 with 4 bits kept. `irq` is high exactly when that AND is nonzero.
- R7: Words written to the transmit queue, and words entering the receive queue, are cut to the frame width, which is control-0 (offset 0x00) bits [3:0] plus one bits.
- R8: Offsets 0xFE0 through 0xFFC return one identification byte per word, in the order 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. The DMA register (offset 0x20) reads 0.
- R9: With control-1 (offset 0x04) bit 1 (enable) and bit 0 (loopback) set, transmit words move one per cycle into the receive queue in order. Movement stalls while the receive queue is full.
- R10: With enable set and loopback clear, a word is offered on `tx_valid`/`tx_data` only when no word is in flight and the receive queue is not full. The word returned on `rx_valid`/`rx_data` is stored in the receive queue.
- R11: A control-1 write with both bit 1 and bit 2 (slave) set, or a nonzero write to the DMA register, sets `err` until reset and changes no register. A zero DMA write has no effect.
- R12: With enable clear, no word leaves the transmit queue.
- R13: The prescaler register (offset 0x10) keeps only the low 8 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| tx_valid | output | 1 | Transmit word offered to the engine |
| tx_data | output | 16 | Transmit word |
| tx_ready | input | 1 | Engine takes the word |
| rx_valid | input | 1 | Engine returns a received word |
| rx_data | input | 16 | Received word |
| rx_ready | output | 1 | A returned word is awaited |
| irq | output | 1 | Level interrupt |
| err | output | 1 | Sticky error for unsupported requests |

## Verification
Every cycle, the assertions check a set of local rules. At most one engine word is in flight. The receive queue is never pushed while full. A full transmit queue stays full under a dropped write. An empty-queue data read returns zero. A zero mask keeps `irq` low. The error flag is sticky. A disabled port moves nothing. Other behaviour depends on sequences and can only be shown by the bench's scenarios: transfer order through loopback and through the engine, the exact interrupt thresholds crossed while draining, frame-width cutting at both ends, the stall when the receive queue is full, and the identification byte order.

// File: rtl/ssp_pkg.sv
// Package: shared offsets, bit positions and the identification bytes for
// the serial port register front end. Assumes a 12-bit byte offset space.
package ssp_pkg;
    localparam logic [11:0] OFF_CTRL0  = 12'h000;
    localparam logic [11:0] OFF_CTRL1  = 12'h004;
    localparam logic [11:0] OFF_DATA   = 12'h008;
    localparam logic [11:0] OFF_STATUS = 12'h00C;
    localparam logic [11:0] OFF_PRESC  = 12'h010;
    localparam logic [11:0] OFF_MASK   = 12'h014;
    localparam logic [11:0] OFF_RAW    = 12'h018;
    localparam logic [11:0] OFF_MASKED = 12'h01C;
    localparam logic [11:0] OFF_DMA    = 12'h020;

    localparam int C1_LOOP  = 0;
    localparam int C1_EN    = 1;
    localparam int C1_SLAVE = 2;

    // Identification byte for word index i of the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0:    return 8'h22;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/ssp_fifo.sv
// Module: ssp_fifo - circular queue with occupancy count.
// Assumes DEPTH is a power of two, and that the caller never pushes when full
// nor pops when empty. Push and pop may happen in the same cycle.
module ssp_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign rdata = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/ssp_flags.sv
// Module: ssp_flags - derives status bits, raw interrupt sources and the
// interrupt line from queue occupancies. Purely combinational; thresholds
// are half the queue depth.
module ssp_flags #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic [3:0]    mask,
    output logic [4:0]    status,
    output logic [3:0]    raw,
    output logic [3:0]    masked,
    output logic          irq
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    // Status and interrupt derivation from counts.
    always_comb begin
        status[0] = (tx_count == '0);
        status[1] = (tx_count != FULL);
        status[2] = (rx_count != '0);
        status[3] = (rx_count == FULL);
        status[4] = (tx_count != '0);
        raw       = {(tx_count <= HALF), (rx_count >= HALF), 2'b00};
        masked    = raw & mask;
        irq       = |masked;
    end
endmodule

// File: rtl/ssp_regfile.sv
// Module: ssp_regfile - register front end of a synchronous serial port.
// Decodes single-cycle APB-style accesses, owns the control registers, the
// two queues and the transfer gating toward loopback or an external engine.
// Assumes one engine word in flight at most; a data-register read pops in
// the same access that returns the word.
module ssp_regfile #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int WORD_W     = 16,
    localparam int FW = $clog2(WORD_W),
    localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              irq,
    output logic              err
);
    import ssp_pkg::*;

    logic [WORD_W-1:0] ctrl0_q;
    logic [3:0]        ctrl1_q;
    logic [7:0]        presc_q;
    logic [3:0]        mask_q;
    logic              err_q, inflight_q;

    logic acc, wr, rd, wr_data, rd_data;
    logic en, loop_sel, lb_move, tx_fire, rx_accept;
    logic tx_push, tx_pop, rx_push, rx_pop;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0]     tx_count, rx_count;
    logic [WORD_W-1:0] width_mask, tx_wdata, tx_rdata, rx_wdata, rx_rdata;
    logic [4:0]        status;
    logic [3:0]        raw, masked;

    assign acc     = psel && penable;
    assign wr      = acc && pwrite;
    assign rd      = acc && !pwrite;
    assign wr_data = wr && (paddr == OFF_DATA);
    assign rd_data = rd && (paddr == OFF_DATA);

    assign en       = ctrl1_q[C1_EN];
    assign loop_sel = ctrl1_q[C1_LOOP];

    // Frame-width mask: bits up to and including the configured width field.
    always_comb begin
        for (int i = 0; i < WORD_W; i++)
            width_mask[i] = (i <= int'(ctrl0_q[FW-1:0]));
    end

    assign lb_move   = en && loop_sel && !tx_empty && !rx_full;
    assign tx_valid  = en && !loop_sel && !tx_empty && !inflight_q && !rx_full;
    assign tx_data   = tx_rdata;
    assign tx_fire   = tx_valid && tx_ready;
    assign rx_ready  = inflight_q;
    assign rx_accept = rx_valid && inflight_q;

    assign tx_push  = wr_data && !tx_full;
    assign tx_wdata = pwdata[WORD_W-1:0] & width_mask;
    assign tx_pop   = lb_move || tx_fire;
    assign rx_push  = lb_move || rx_accept;
    assign rx_wdata = (lb_move ? tx_rdata : rx_data) & width_mask;
    assign rx_pop   = rd_data && !rx_empty;

    ssp_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_rdata), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_rdata), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    ssp_flags #(.DEPTH(FIFO_DEPTH)) u_flags (
        .tx_count(tx_count), .rx_count(rx_count), .mask(mask_q),
        .status(status), .raw(raw), .masked(masked), .irq(irq)
    );

    // Register writes and the sticky error for unsupported requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
            presc_q <= '0;
            mask_q  <= '0;
            err_q   <= 1'b0;
        end else if (wr) begin
            case (paddr)
                OFF_CTRL0: ctrl0_q <= pwdata[WORD_W-1:0];
                OFF_CTRL1: begin
                    if (pwdata[C1_EN] && pwdata[C1_SLAVE]) err_q <= 1'b1;
                    else ctrl1_q <= pwdata[3:0];
                end
                OFF_PRESC: presc_q <= pwdata[7:0];
                OFF_MASK:  mask_q  <= pwdata[3:0];
                OFF_DMA:   if (pwdata != '0) err_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Engine word-in-flight tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)         inflight_q <= 1'b0;
        else if (tx_fire)   inflight_q <= 1'b1;
        else if (rx_accept) inflight_q <= 1'b0;
    end

    assign err = err_q;

    // Read data selection for the access phase.
    always_comb begin
        prdata = '0;
        if (rd) begin
            if (paddr[ADDR_W-1:5] == '1 && paddr[1:0] == 2'b00)
                prdata = DATA_W'(id_byte(paddr[4:2]));
            else begin
                case (paddr)
                    OFF_CTRL0:  prdata = DATA_W'(ctrl0_q);
                    OFF_CTRL1:  prdata = DATA_W'(ctrl1_q);
                    OFF_DATA:   prdata = rx_empty ? '0 : DATA_W'(rx_rdata);
                    OFF_STATUS: prdata = DATA_W'(status);
                    OFF_PRESC:  prdata = DATA_W'(presc_q);
                    OFF_MASK:   prdata = DATA_W'(mask_q);
                    OFF_RAW:    prdata = DATA_W'(raw);
                    OFF_MASKED: prdata = DATA_W'(masked);
                    default:    prdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ssp_regfile_chk.sv
// Module: ssp_regfile_chk - cycle-by-cycle rules for ssp_regfile, bound to
// every instance of it. Assumes the synchronous active-low reset.
module ssp_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_push,
    input logic              rx_full,
    input logic              wr_data,
    input logic              tx_full,
    input logic              tx_pop,
    input logic              rd_data,
    input logic              rx_empty,
    input logic [DATA_W-1:0] prdata,
    input logic [3:0]        mask_q,
    input logic              irq,
    input logic              err,
    input logic              en
);
    assert_single_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_valid);
    assert_rx_push_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full && !tx_pop) |=> tx_full);
    assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rx_empty) |-> (prdata == '0));
    assert_no_mask_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 4'h0) |-> !irq);
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tx_pop);
endmodule

bind ssp_regfile ssp_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_push(rx_push), .rx_full(rx_full), .wr_data(wr_data),
    .tx_full(tx_full), .tx_pop(tx_pop), .rd_data(rd_data),
    .rx_empty(rx_empty), .prdata(prdata), .mask_q(mask_q), .irq(irq),
    .err(err), .en(en)
);

// File: tb/sim_ssp_regfile.sv
// Bench: scoreboard for ssp_regfile. Read tasks queue expected values; a
// monitor compares each access-phase read. A one-cycle engine model echoes
// each launched word inverted.
module sim_ssp_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        tx_valid, rx_ready, irq, err;
    logic [15:0] tx_data;
    logic        eng_v;
    logic [15:0] eng_d;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    ssp_regfile u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(1'b1),
        .rx_valid(eng_v), .rx_data(eng_d), .rx_ready(rx_ready),
        .irq(irq), .err(err)
    );

    // Engine model: returns the inverted word one cycle after launch.
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_v <= 1'b0;
            eng_d <= '0;
        end else begin
            eng_v <= tx_valid;
            eng_d <= ~tx_data;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input int exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // Monitor: compares each read in its access phase, away from the edge.
    always @(negedge clk) begin
        #8;
        if (psel && penable && !pwrite) begin
            if (exp_q.size() == 0) check("monitor underrun", 1, 0);
            else check(tag_q.pop_front(), int'(prdata), exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(12'h00C, 32'h03, "R1 status");
        bus_read(12'h018, 32'h08, "R1 raw");
        bus_read(12'h014, 32'h00, "R1 mask");
        check("R1 irq", int'(irq), 0);
        check("R1 err", int'(err), 0);
        // R4 empty read
        bus_read(12'h008, 0, "R4 empty read");
        bus_read(12'h00C, 32'h03, "R4 nothing popped");
        // R13 prescaler
        bus_write(12'h010, 32'h1234);
        bus_read(12'h010, 32'h34, "R13 prescaler");
        // R7/R3/R12: 8-bit frames, disabled, nine writes
        bus_write(12'h000, 32'h7);
        for (int i = 0; i < 9; i++) bus_write(12'h008, 32'h3C0 + i);
        repeat (4) @(negedge clk);
        bus_read(12'h00C, 32'h10, "R2 R3 R12 full tx, nothing moved");
        bus_read(12'h018, 32'h00, "R5 raw with tx 8 rx 0");
        bus_write(12'h014, 32'hC);
        check("R6 irq low with raw 0", int'(irq), 0);
        // R9 loopback
        bus_write(12'h004, 32'h3);
        repeat (12) @(negedge clk);
        bus_read(12'h00C, 32'h0F, "R2 R9 rx full");
        bus_read(12'h018, 32'h0C, "R5 raw rx 8 tx 0");
        bus_read(12'h01C, 32'h0C, "R6 masked");
        check("R6 irq high", int'(irq), 1);
        bus_write(12'h008, 32'h55);
        repeat (3) @(negedge clk);
        bus_read(12'h00C, 32'h1E, "R9 stalled while rx full");
        for (int i = 0; i < 9; i++) begin
            bus_read(12'h008, (i < 8) ? (32'hC0 + i) : 32'h55, "R7 R9 loopback order");
            if (i == 4) bus_read(12'h018, 32'h0C, "R5 rx 4 threshold");
            if (i == 5) bus_read(12'h018, 32'h08, "R5 rx 3 below threshold");
        end
        bus_read(12'h008, 0, "R4 drained read");
        bus_read(12'h00C, 32'h03, "R2 all empty");
        check("R6 irq from tx source", int'(irq), 1);
        bus_write(12'h014, 32'h4);
        check("R6 irq masked off", int'(irq), 0);
        bus_read(12'h01C, 32'h00, "R6 masked zero");
        // R11 errors
        bus_write(12'h020, 32'h0);
        check("R11 zero DMA no error", int'(err), 0);
        bus_write(12'h020, 32'h1);
        check("R11 DMA error", int'(err), 1);
        bus_write(12'h004, 32'h6);
        bus_read(12'h004, 32'h3, "R11 ctrl1 unchanged");
        check("R11 err sticky", int'(err), 1);
        // R8 identification and DMA read
        bus_read(12'h020, 0, "R8 DMA reads zero");
        for (int i = 0; i < 8; i++) begin
            int idv;
            case (i)
                0: idv = 32'h22; 1: idv = 32'h10; 2: idv = 32'h04; 3: idv = 32'h00;
                4: idv = 32'h0D; 5: idv = 32'hF0; 6: idv = 32'h05; default: idv = 32'hB1;
            endcase
            bus_read(12'hFE0 + 12'(4 * i), idv, "R8 id byte");
        end
        // R10 external engine, full 16-bit frames
        bus_write(12'h000, 32'hF);
        bus_write(12'h004, 32'h2);
        bus_write(12'h008, 32'h1234);
        bus_write(12'h008, 32'hABCD);
        bus_write(12'h008, 32'h8001);
        repeat (20) @(negedge clk);
        bus_read(12'h008, 32'hEDCB, "R10 engine word 0");
        bus_read(12'h008, 32'h5432, "R10 engine word 1");
        bus_read(12'h008, 32'h7FFE, "R10 engine word 2");
        // R7 receive-side cut to 4 bits
        bus_write(12'h000, 32'h3);
        bus_read(12'h000, 32'h3, "R7 ctrl0 readback");
        bus_write(12'h008, 32'h00F0);
        repeat (10) @(negedge clk);
        bus_read(12'h008, 32'h000F, "R7 rx word cut to 4 bits");
        bus_read(12'h00C, 32'h03, "R10 queues empty");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule